// File: doc/BRIEF.md
# Fractional Clock Rate Controller

This block turns a free-running clock into a clock-enable stream that passes a chosen fraction `mult/32` of the clock edges, where `mult` can be anything from 1 to 32. The fraction is chosen through a small register port. Software puts a rate code, equal to `32 - mult`, into a rate register. That code sits there and does nothing until software sets a commit bit in a second register. The commit bit is then cleared by hardware.

Time is divided into windows of 32 cycles, and a staged code becomes active only on the edge that ends a window. Inside a window, an accumulator spreads the enables as evenly as possible. Software tells that a change has landed by polling the commit bit until it reads zero. While the commit bit is still set, any write to the rate register is refused, and the block flags that refusal for one cycle.

The window length is `2**CODE_W`. The register addresses and the bit positions of both fields are parameters. A further parameter inserts an optional output register stage.

Top module: `frc_rate_ctrl`

## Requirements
- R1: Reset leaves the rate register at zero and the commit bit clear. After reset, `rate_en` is high in every cycle (mult = 32).
- R2: With an active code `c`, held in bits 12:8 of the rate register (address 2), each 32-cycle window holds exactly `mult = 32 - c` enables. Code 0 means 32.
- R3: Enables are spread evenly. `win_first` is high in window cycle 0. In window cycle `p`, `rate_en` is high exactly when `floor((p+1)*mult/32) > floor(p*mult/32)`.
- R4: A write with bit 31 set to the commit register (address 1) sets the commit bit. Hardware clears the bit on the edge that ends the current window, so within 32 cycles. The new rate takes effect from the window that starts at that edge.
- R5: A write to the rate register while the commit bit is set is discarded and leaves the register unchanged. `wr_reject` is then high for the one cycle after the write.
- R6: A rate code written without a commit does not change the output pattern.
- R7: The bits of the rate register outside 12:8 read back exactly as written, and committing a code leaves them untouched.
- R8: A write to the commit register with bit 31 clear has no effect. All bits of that register other than bit 31 read as zero.
- R9: A read from any address other than 1 or 2 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Word address for both reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, a combinational function of `bus_addr` |
| rate_en | output | 1 | Clock-enable pulse stream |
| win_first | output | 1 | High in cycle 0 of each 32-cycle window |
| wr_reject | output | 1 | One-cycle flag for a refused rate write |

## Verification
The bench sweeps every `mult` from 32 down to 1. For each value it fills the bits outside the code field with a different pattern, and it compares every cycle of one window against the floor formula. This tells a wrong enable count apart from a correct count placed in the wrong cycles. It also catches an inverted or offset code. Separate tests cover:
- a commit issued while the old rate is still running, to check that the change lands exactly on a window boundary and within the latency bound;
- an uncommitted code, which must leave the pattern unchanged;
- a rate write during a pending commit;
- commit writes with bit 31 clear.

// File: rtl/frc_pkg.sv
package frc_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_KICK = 2'd1,
      SEL_RATE = 2'd2
   } frc_sel_e;

endpackage

// File: rtl/frc_regs.sv
module frc_regs
   import frc_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4,
   parameter int KICK_ADDR = 1,
   parameter int RATE_ADDR = 2,
   parameter int KICK_BIT  = 31,
   parameter int CODE_LSB  = 8,
   parameter int CODE_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              apply,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] rate_q,
   output logic [CODE_W-1:0] pend_code,
   output logic              busy,
   output logic              wr_reject
);

   localparam logic [ADDR_W-1:0] KICK_A = ADDR_W'(KICK_ADDR);
   localparam logic [ADDR_W-1:0] RATE_A = ADDR_W'(RATE_ADDR);

   frc_sel_e sel;
   logic     kick_q;
   logic     rej_q;
   logic     rate_wr_ok;
   logic     kick_set;

   always_comb begin
      if (bus_addr == KICK_A)      sel = SEL_KICK;
      else if (bus_addr == RATE_A) sel = SEL_RATE;
      else                         sel = SEL_NONE;
   end

   assign rate_wr_ok = bus_wr && (sel == SEL_RATE) && !kick_q;
   assign kick_set   = bus_wr && (sel == SEL_KICK) && bus_wdata[KICK_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q <= '0;
      end else if (rate_wr_ok) begin
         rate_q <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kick_q <= 1'b0;
      end else if (apply) begin
         kick_q <= 1'b0;
      end else if (kick_set) begin
         kick_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rej_q <= 1'b0;
      end else begin
         rej_q <= bus_wr && (sel == SEL_RATE) && kick_q;
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (sel)
         SEL_KICK: bus_rdata[KICK_BIT] = kick_q;
         SEL_RATE: bus_rdata = rate_q;
         default:  bus_rdata = '0;
      endcase
   end

   assign pend_code = rate_q[CODE_LSB +: CODE_W];
   assign busy      = kick_q;
   assign wr_reject = rej_q;

endmodule

// File: rtl/frc_phase.sv
module frc_phase #(
   parameter int CODE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic [CODE_W-1:0] pend_code,
   output logic              win_first,
   output logic              win_last,
   output logic              apply,
   output logic [CODE_W-1:0] active_code
);

   logic [CODE_W-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end

   assign win_first = (phase_q == '0);
   assign win_last  = &phase_q;
   assign apply     = busy && win_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_code <= '0;
      end else if (apply) begin
         active_code <= pend_code;
      end
   end

endmodule

// File: rtl/frc_accum.sv
module frc_accum #(
   parameter int CODE_W  = 5,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] active_code,
   input  logic              win_first_i,
   output logic              en_o,
   output logic              win_first_o,
   output logic [CODE_W-1:0] acc_o
);

   localparam logic [CODE_W:0] WIN = (CODE_W+1)'(1) << CODE_W;

   logic [CODE_W:0]   mult;
   logic [CODE_W-1:0] acc_q;
   logic [CODE_W:0]   sum;
   logic              ovf;

   assign mult = WIN - {1'b0, active_code};
   assign sum  = {1'b0, acc_q} + mult;
   assign ovf  = sum[CODE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else begin
         acc_q <= sum[CODE_W-1:0];
      end
   end

   assign acc_o = acc_q;

   generate
      if (OUT_REG) begin : g_reg_out
         logic en_q;
         logic wf_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               en_q <= 1'b0;
               wf_q <= 1'b0;
            end else begin
               en_q <= ovf;
               wf_q <= win_first_i;
            end
         end
         assign en_o        = en_q;
         assign win_first_o = wf_q;
      end else begin : g_comb_out
         assign en_o        = ovf;
         assign win_first_o = win_first_i;
      end
   endgenerate

endmodule

// File: rtl/frc_rate_ctrl.sv
module frc_rate_ctrl #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4,
   parameter int KICK_ADDR = 1,
   parameter int RATE_ADDR = 2,
   parameter int KICK_BIT  = 31,
   parameter int CODE_LSB  = 8,
   parameter int CODE_W    = 5,
   parameter bit OUT_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              rate_en,
   output logic              win_first,
   output logic              wr_reject
);

   generate
      if (CODE_LSB + CODE_W > DATA_W) begin : g_bad_field
         $error("rate code field exceeds register width");
      end
      if (KICK_BIT >= DATA_W) begin : g_bad_kick
         $error("commit bit outside register width");
      end
      if (KICK_ADDR == RATE_ADDR) begin : g_bad_addr
         $error("register addresses collide");
      end
      if (CODE_W < 1 || CODE_W > 10) begin : g_bad_code
         $error("CODE_W out of supported range");
      end
   endgenerate

   logic [DATA_W-1:0] rate_q;
   logic [CODE_W-1:0] pend_code;
   logic [CODE_W-1:0] active_code;
   logic [CODE_W-1:0] acc_mon;
   logic              busy;
   logic              apply;
   logic              win_last;
   logic              win_first_raw;

   frc_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .KICK_ADDR(KICK_ADDR),
      .RATE_ADDR(RATE_ADDR), .KICK_BIT(KICK_BIT), .CODE_LSB(CODE_LSB),
      .CODE_W(CODE_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .apply(apply), .bus_rdata(bus_rdata),
      .rate_q(rate_q), .pend_code(pend_code), .busy(busy),
      .wr_reject(wr_reject)
   );

   frc_phase #(.CODE_W(CODE_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .busy(busy), .pend_code(pend_code),
      .win_first(win_first_raw), .win_last(win_last), .apply(apply),
      .active_code(active_code)
   );

   frc_accum #(.CODE_W(CODE_W), .OUT_REG(OUT_REG)) u_accum (
      .clk(clk), .rst_n(rst_n), .active_code(active_code),
      .win_first_i(win_first_raw), .en_o(rate_en),
      .win_first_o(win_first), .acc_o(acc_mon)
   );

endmodule

// File: rtl/frc_rate_ctrl_chk.sv
module frc_rate_ctrl_chk #(
   parameter int DATA_W = 32,
   parameter int CODE_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              win_last,
   input logic              bus_wr,
   input logic              wr_reject,
   input logic [CODE_W-1:0] active_code,
   input logic [CODE_W-1:0] acc,
   input logic [DATA_W-1:0] rate_q
);

   localparam int WIN = 1 << CODE_W;

   logic [CODE_W+1:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_cnt <= '0;
      else if (busy) busy_cnt <= busy_cnt + 1'b1;
      else           busy_cnt <= '0;
   end

   AST_KICK_CLEARS_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(win_last)); // R4

   AST_KICK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= (CODE_W+2)'(WIN)); // R4

   AST_CODE_HELD_MIDWINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(win_last) |-> $stable(active_code)); // R6

   AST_REJECT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reject |-> ($past(busy) && $past(bus_wr))); // R5

   AST_RATE_FROZEN_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> $stable(rate_q)); // R5

   AST_FULL_RATE_ACC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (active_code == '0 && $past(active_code) == '0) |-> (acc == '0)); // R2

endmodule

bind frc_rate_ctrl frc_rate_ctrl_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .win_last(win_last),
   .bus_wr(bus_wr), .wr_reject(wr_reject), .active_code(active_code),
   .acc(acc_mon), .rate_q(rate_q)
);

// File: tb/frc_rate_ctrl_bench.sv
module frc_rate_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int AW = 4;
   localparam int WIN = 32;
   localparam logic [AW-1:0] A_KICK = 4'd1;
   localparam logic [AW-1:0] A_RATE = 4'd2;
   localparam logic [DW-1:0] CODE_MASK = 32'h0000_1F00;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          rate_en;
   logic          win_first;
   logic          wr_reject;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   frc_rate_ctrl u_frc_rate_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rate_en(rate_en),
      .win_first(win_first), .wr_reject(wr_reject)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_window_start();
      @(negedge clk);
      while (!win_first) @(negedge clk);
   endtask

   // Called at a negedge in window cycle 0; checks all cycles of the window.
   task automatic check_window(input int m, input string req);
      int cnt = 0;
      for (int p = 0; p < WIN; p++) begin
         bit exp_en;
         if (p > 0) @(negedge clk);
         exp_en = (((p+1)*m)/WIN) != ((p*m)/WIN);
         check(win_first == (p == 0), "R3 window marker", win_first, p == 0);
         check(rate_en == exp_en, req, rate_en, exp_en);
         if (rate_en) cnt++;
      end
      check(cnt == m, "R2 enable count", cnt, m);
   endtask

   task automatic wait_commit(output int polls);
      logic [DW-1:0] r;
      polls = 0;
      do begin
         bus_read(A_KICK, r);
         polls++;
      end while (r[31] && polls < 100);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] r;
      logic [DW-1:0] wd;
      int polls;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      bus_read(A_RATE, r);
      check(r == '0, "R1 rate reg reset", r, 0);
      bus_read(A_KICK, r);
      check(r == '0, "R1 kick reg reset", r, 0);
      wait_window_start();
      check_window(32, "R1 full rate after reset");

      // R9: unmapped address
      bus_read(4'd5, r);
      check(r == '0, "R9 unmapped read", r, 0);
      bus_read(4'd0, r);
      check(r == '0, "R9 unmapped read", r, 0);

      // R2/R3/R4/R7 sweep over every mult
      for (int m = WIN; m >= 1; m--) begin
         wd = ((32'hA5C3_96E1 ^ (m * 32'h0101_0137)) & ~CODE_MASK) | (32'(WIN - m) << 8);
         bus_write(A_RATE, wd);
         bus_read(A_RATE, r);
         check(r == wd, "R7 readback before commit", r, wd);
         bus_write(A_KICK, 32'h8000_0000);
         wait_commit(polls);
         check(polls <= WIN, "R4 commit latency", polls, WIN);
         check(win_first == 1'b1, "R4 clears at window boundary", win_first, 1);
         check_window(m, "R2 R3 pattern after commit");
         bus_read(A_RATE, r);
         check(r == wd, "R7 readback after commit", r, wd);
      end

      // R6: uncommitted code keeps mult=1 pattern
      bus_write(A_RATE, 32'(WIN - 5) << 8);
      wait_window_start();
      check_window(1, "R6 no effect without commit");
      wait_window_start();
      check_window(1, "R6 no effect without commit");

      // R5: rate write during pending commit is discarded
      bus_write(A_KICK, 32'h8000_0000);
      bus_write(A_RATE, 32'(WIN - 17) << 8);
      check(wr_reject == 1'b1, "R5 reject flag", wr_reject, 1);
      @(negedge clk);
      check(wr_reject == 1'b0, "R5 reject flag single cycle", wr_reject, 0);
      bus_read(A_RATE, r);
      check(r == (32'(WIN - 5) << 8), "R5 rate reg unchanged", r, 32'(WIN - 5) << 8);
      wait_commit(polls);
      wait_window_start();
      check_window(5, "R5 staged code kept");

      // R8: commit writes without bit 31
      bus_write(A_RATE, 32'(WIN - 9) << 8);
      check(wr_reject == 1'b0, "R5 accepted write not flagged", wr_reject, 0);
      bus_write(A_KICK, 32'h7FFF_FFFF);
      bus_read(A_KICK, r);
      check(r == '0, "R8 kick bit-clear write ignored", r, 0);
      wait_window_start();
      check_window(5, "R8 no commit from zero kick bit");
      bus_write(A_KICK, 32'hFFFF_FFFF);
      #1;
      check(bus_rdata == 32'h8000_0000, "R8 only commit bit reads", bus_rdata, 32'h8000_0000);
      wait_commit(polls);
      check(polls <= WIN, "R4 commit latency", polls, WIN);
      wait_window_start();
      check_window(9, "R2 pattern after final commit");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule